// File: doc/BRIEF.md
# Byte/Word Memory Bus Decoder

This block sits behind a 16-bit processor memory port and answers every access on its own. Each access carries a 16-bit byte address, a 16-bit data word, a size select that picks one byte or one 16-bit word, and separate read and write strobes. The block works out which region the address falls into and checks the access against that region's width rule. It then either serves the access or flags it as illegal.

The regions are a small byte-only control area, a byte-only peripheral window, a word-only peripheral window, a 128-byte RAM, and a read-only program area whose top 32 bytes hold the interrupt vectors. All writable regions are held internally as byte arrays. Words are stored little-endian: the low byte sits at the even address and the high byte at the odd address above it. The read-only image is not stored at all. It is computed arithmetically from three parameters, so a bench can predict every word of it.

The bus is a plain strobe interface with no back-pressure. A read is answered combinationally in the cycle it is presented. A write is committed at the next rising clock edge. There is no valid/ready pairing, because an access can never stall.

Top module: `mbd_bus_decoder`

## Requirements
- R1: The region map is fixed. Bytes 0x0000-0x000F form the control area and 0x0010-0x00FF the byte peripheral window; both are byte-only. 0x0100-0x01FF is the word peripheral window and is word-only. 0x0200-0x027F is RAM and 0xF800-0xFFDF is program image; both allow byte and word access. 0xFFE0-0xFFFF is the vector area and also allows both widths. Every other address is unmapped.
- R2: A word access (`byte_sel`=0) with `addr[0]`=1 raises `acc_err` in the same cycle, whatever the region.
- R3: A word access to a byte-only region raises `acc_err`, and so does a byte access to the word-only region.
- R4: An access that raises `acc_err` returns `rdata`=0x0000 and changes no stored byte.
- R5: A word write of W to an even address A stores W[7:0] at A and W[15:8] at A+1. A word read returns {byte at A+1, byte at A}.
- R6: A byte read returns the addressed byte in `rdata[7:0]`, with `rdata[15:8]`=0. A byte write stores `wdata[7:0]` at the addressed byte only.
- R7: The program-image word at even address A equals the low 16 bits of A*`IMG_MUL`+`IMG_ADD`. The vector word at even address A equals A XOR `VEC_KEY`. A byte read of the odd address gives the high byte. Writes to either area store nothing and raise `acc_err`.
- R8: Reads of unmapped addresses return 0x0000 without `acc_err`. Writes to them store nothing and raise no error, unless R2 applies.
- R9: Read data is valid combinationally in the cycle `rd_en` is high. A write takes effect at the rising edge on which `wr_en` is high. While `rd_en` is low, `rdata` is 0x0000.
- R10: A synchronous reset (`rst` high at a rising edge) clears every RAM and register byte to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Byte address of the access |
| wdata | input | 16 | Write data; byte writes use bits [7:0] |
| byte_sel | input | 1 | 1 = byte access, 0 = word access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rdata | output | 16 | Read data, combinational |
| acc_err | output | 1 | Illegal access flag for the current cycle |

## Verification
Every byte of the writable regions is written with an address-derived pattern. It is then read back with both widths, which separates correct lane order from swapped lanes and from byte writes that spill into the neighbouring byte. Each region is also hit with the width it forbids and with odd word addresses. After each illegal write, a legal read confirms that storage is unchanged, which separates error flagging from error gating. The full program image and vector area are read word by word against the arithmetic formula. Address bands just outside each region are read and written, to catch off-by-one region bounds. A reset in the middle of the run must zero all storage again.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;
  localparam int unsigned BW = 8;

  localparam logic [AW-1:0] CTL_HI  = 16'h000F;
  localparam logic [AW-1:0] PB_HI   = 16'h00FF;
  localparam logic [AW-1:0] PW_LO   = 16'h0100;
  localparam logic [AW-1:0] PW_HI   = 16'h01FF;
  localparam logic [AW-1:0] RAM_LO  = 16'h0200;
  localparam logic [AW-1:0] RAM_HI  = 16'h027F;
  localparam logic [AW-1:0] IMG_LO  = 16'hF800;
  localparam logic [AW-1:0] VEC_LO  = 16'hFFE0;

  localparam int unsigned N_STORES = 4;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTL, RG_PB, RG_PW, RG_RAM, RG_IMG, RG_VEC
  } region_t;

  function automatic region_t store_region(int unsigned g);
    case (g)
      0: return RG_CTL;
      1: return RG_PB;
      2: return RG_PW;
      default: return RG_RAM;
    endcase
  endfunction

  function automatic int unsigned store_base(int unsigned g);
    case (g)
      0: return 32'h0000;
      1: return 32'h0010;
      2: return 32'h0100;
      default: return 32'h0200;
    endcase
  endfunction

  function automatic int unsigned store_depth(int unsigned g);
    case (g)
      0: return 16;
      1: return 240;
      2: return 256;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/mbd_decode.sv
module mbd_decode
  import mbd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          byte_sel,
  input  logic          rd_en,
  input  logic          wr_en,
  output region_t       region,
  output logic          err
);
  logic byte_only, word_only, rom_area, bad_align, bad_width, rom_wr;

  always_comb begin
    region = RG_NONE;
    if (addr <= CTL_HI)                          region = RG_CTL;
    else if (addr <= PB_HI)                      region = RG_PB;
    else if (addr >= PW_LO && addr <= PW_HI)     region = RG_PW;
    else if (addr >= RAM_LO && addr <= RAM_HI)   region = RG_RAM;
    else if (addr >= VEC_LO)                     region = RG_VEC;
    else if (addr >= IMG_LO)                     region = RG_IMG;
  end

  assign byte_only = (region == RG_CTL) || (region == RG_PB);
  assign word_only = (region == RG_PW);
  assign rom_area  = (region == RG_IMG) || (region == RG_VEC);
  assign bad_align = !byte_sel && addr[0];
  assign bad_width = (byte_only && !byte_sel) || (word_only && byte_sel);
  assign rom_wr    = wr_en && rom_area;
  assign err       = (rd_en || wr_en) && (bad_align || bad_width || rom_wr);

  AST_ROM_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr >= IMG_LO) |-> err); // R7
  AST_LOW_BYTE_AREA: assert property (@(posedge clk) disable iff (rst)
    (addr <= PB_HI) |-> (region == RG_CTL || region == RG_PB)); // R1
endmodule

// File: rtl/mbd_byte_store.sv
module mbd_byte_store
  import mbd_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OFF_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] off,
  input  logic             byte_mode,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [BW-1:0] mem [DEPTH];
  logic [OFF_W-1:0] off_lo, off_hi;

  assign off_lo = {off[OFF_W-1:1], 1'b0};
  assign off_hi = {off[OFF_W-1:1], 1'b1};

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
    logic hit;
    logic [BW-1:0] lane;
    assign hit  = we && (byte_mode ? (off == IDX) : (off[OFF_W-1:1] == IDX[OFF_W-1:1]));
    assign lane = (byte_mode || !IDX[0]) ? wdata[BW-1:0] : wdata[DW-1:BW];
    always_ff @(posedge clk) begin
      if (rst)      mem[i] <= '0;
      else if (hit) mem[i] <= lane;
    end
  end

  assign rdata = byte_mode ? {{BW{1'b0}}, mem[off]} : {mem[off_hi], mem[off_lo]};

  AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (32'(off) < DEPTH)); // R1
endmodule

// File: rtl/mbd_rom_image.sv
module mbd_rom_image
  import mbd_pkg::*;
#(
  parameter logic [DW-1:0] IMG_MUL = 16'h9D3B,
  parameter logic [DW-1:0] IMG_ADD = 16'h1234,
  parameter logic [DW-1:0] VEC_KEY = 16'hA5C3
) (
  input  logic [AW-1:0] addr,
  input  logic          byte_sel,
  input  logic          in_vec,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] waddr;
  logic [DW-1:0] word;

  assign waddr = {addr[AW-1:1], 1'b0};
  assign word  = in_vec ? (waddr ^ VEC_KEY) : DW'(waddr * IMG_MUL + IMG_ADD);
  assign rdata = byte_sel ? {{BW{1'b0}}, (addr[0] ? word[DW-1:BW] : word[BW-1:0])} : word;
endmodule

// File: rtl/mbd_bus_decoder.sv
module mbd_bus_decoder
  import mbd_pkg::*;
#(
  parameter logic [15:0] IMG_MUL = 16'h9D3B,
  parameter logic [15:0] IMG_ADD = 16'h1234,
  parameter logic [15:0] VEC_KEY = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  input  logic        byte_sel,
  input  logic        rd_en,
  input  logic        wr_en,
  output logic [15:0] rdata,
  output logic        acc_err
);
  region_t       region;
  logic          err;
  logic [DW-1:0] st_rd  [N_STORES];
  logic [DW-1:0] rom_rd;
  logic [DW-1:0] rd_mux;

  mbd_decode u_dec (
    .clk(clk), .rst(rst), .addr(addr), .byte_sel(byte_sel),
    .rd_en(rd_en), .wr_en(wr_en), .region(region), .err(err)
  );

  for (genvar g = 0; g < N_STORES; g++) begin : g_store
    localparam int unsigned DEP = store_depth(g);
    localparam int unsigned OW  = $clog2(DEP);
    logic [AW-1:0] rel;
    logic          we;
    assign rel = addr - AW'(store_base(g));
    assign we  = wr_en && !err && (region == store_region(g));
    mbd_byte_store #(.DEPTH(DEP), .OFF_W(OW)) u_st (
      .clk(clk), .rst(rst), .off(rel[OW-1:0]), .byte_mode(byte_sel),
      .we(we), .wdata(wdata), .rdata(st_rd[g])
    );
  end

  mbd_rom_image #(.IMG_MUL(IMG_MUL), .IMG_ADD(IMG_ADD), .VEC_KEY(VEC_KEY)) u_rom (
    .addr(addr), .byte_sel(byte_sel), .in_vec(region == RG_VEC), .rdata(rom_rd)
  );

  always_comb begin
    case (region)
      RG_CTL:          rd_mux = st_rd[0];
      RG_PB:           rd_mux = st_rd[1];
      RG_PW:           rd_mux = st_rd[2];
      RG_RAM:          rd_mux = st_rd[3];
      RG_IMG, RG_VEC:  rd_mux = rom_rd;
      default:         rd_mux = '0;
    endcase
  end

  assign rdata   = (rd_en && !err) ? rd_mux : '0;
  assign acc_err = err;

  AST_ODD_WORD_ERR: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && !byte_sel && addr[0]) |-> acc_err); // R2
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc_err) |-> (rdata == 16'h0000)); // R4
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && byte_sel) |-> (rdata[15:8] == 8'h00)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rdata == 16'h0000)); // R9
  AST_WORD_ONLY_ERR: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && byte_sel && addr >= 16'h0100 && addr <= 16'h01FF) |-> acc_err); // R3
endmodule

// File: tb/tb_mbd_bus_decoder.sv
module tb_mbd_bus_decoder;
  localparam logic [15:0] MUL = 16'h9D3B;
  localparam logic [15:0] ADD = 16'h1234;
  localparam logic [15:0] KEY = 16'hA5C3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] addr = '0, wdata = '0;
  logic byte_sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] rdata;
  logic acc_err;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] shadow [0:16'h027F];

  always #5 clk = ~clk;

  mbd_bus_decoder #(.IMG_MUL(MUL), .IMG_ADD(ADD), .VEC_KEY(KEY)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .byte_sel(byte_sel),
    .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata), .acc_err(acc_err)
  );

  function automatic bit exp_err(logic [15:0] a, logic b, logic wr);
    bit e;
    e = (!b && a[0]) || (a <= 16'h00FF && !b) || (a >= 16'h0100 && a <= 16'h01FF && b);
    if (wr && a >= 16'hF800) e = 1;
    return e;
  endfunction

  function automatic logic [15:0] exp_data(logic [15:0] a, logic b);
    logic [15:0] w, wa;
    wa = {a[15:1], 1'b0};
    if (exp_err(a, b, 1'b0)) return 16'h0000;
    if (a <= 16'h027F) return b ? {8'h00, shadow[a]} : {shadow[a | 16'h1], shadow[wa]};
    if (a >= 16'hF800) begin
      w = (a >= 16'hFFE0) ? (wa ^ KEY) : 16'(wa * MUL + ADD);
      return b ? {8'h00, (a[0] ? w[15:8] : w[7:0])} : w;
    end
    return 16'h0000;
  endfunction

  task automatic chk(string tag, logic [15:0] a, logic [15:0] got_d, logic got_e,
                     logic [15:0] ex_d, logic ex_e);
    n_tests++;
    if (got_d !== ex_d || got_e !== ex_e) begin
      n_fail++;
      $display("FAIL %s addr=%h data=%h exp=%h err=%b exp=%b", tag, a, got_d, ex_d, got_e, ex_e);
    end
  endtask

  task automatic rd(string tag, logic [15:0] a, logic b);
    @(negedge clk);
    addr = a; byte_sel = b; rd_en = 1; wr_en = 0;
    #1;
    chk(tag, a, rdata, acc_err, exp_data(a, b), exp_err(a, b, 1'b0));
    rd_en = 0;
  endtask

  task automatic wr(string tag, logic [15:0] a, logic [15:0] d, logic b);
    bit e;
    @(negedge clk);
    addr = a; wdata = d; byte_sel = b; wr_en = 1; rd_en = 0;
    #1;
    e = exp_err(a, b, 1'b1);
    chk(tag, a, 16'h0000, acc_err, 16'h0000, e);
    @(posedge clk);
    #1 wr_en = 0;
    if (!e && a <= 16'h027F) begin
      if (b) shadow[a] = d[7:0];
      else begin shadow[a] = d[7:0]; shadow[a + 16'h1] = d[15:8]; end
    end
  endtask

  task automatic sweep_zero(string tag);
    for (int a = 0; a < 16'h0280; a++) begin
      if (a >= 16'h0100 && a <= 16'h01FF) begin
        if (a % 2 == 0) rd(tag, 16'(a), 1'b0);
      end else rd(tag, 16'(a), 1'b1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int i = 0; i < 16'h0280; i++) shadow[i] = 8'h00;
  endtask

  initial begin
    for (int i = 0; i < 16'h0280; i++) shadow[i] = 8'h00;
    do_reset();
    sweep_zero("R10 reset");

    // R6 / R1: byte-only areas, pattern per byte
    for (int a = 0; a < 16'h0100; a++) wr("R6 byte wr", 16'(a), 16'(a ^ 16'hA75C), 1'b1);
    for (int a = 0; a < 16'h0100; a++) rd("R6 R1 byte rd", 16'(a), 1'b1);
    for (int a = 0; a < 16'h0100; a += 16) rd("R3 word rd byte-only", 16'(a), 1'b0);
    wr("R3 word wr byte-only", 16'h0020, 16'hBEEF, 1'b0);
    wr("R3 word wr ctl", 16'h0004, 16'hBEEF, 1'b0);
    rd("R4 unchanged 0020", 16'h0020, 1'b1);
    rd("R4 unchanged 0021", 16'h0021, 1'b1);
    rd("R4 unchanged 0004", 16'h0004, 1'b1);

    // R9: idle read returns zero
    @(negedge clk); addr = 16'h0020; byte_sel = 1; rd_en = 0; #1;
    chk("R9 idle", 16'h0020, rdata, acc_err, 16'h0000, 1'b0);

    // word-only window
    for (int a = 16'h0100; a < 16'h0200; a += 2) wr("R5 word wr pw", 16'(a), 16'(a * 7 + 16'h0F0F), 1'b0);
    for (int a = 16'h0100; a < 16'h0200; a += 2) rd("R5 word rd pw", 16'(a), 1'b0);
    for (int a = 16'h0100; a < 16'h0200; a += 17) rd("R3 byte rd pw", 16'(a), 1'b1);
    wr("R3 byte wr pw", 16'h0140, 16'h00AA, 1'b1);
    rd("R4 pw unchanged", 16'h0140, 1'b0);

    // RAM: little-endian lanes and byte merge
    for (int a = 16'h0200; a < 16'h0280; a += 2) wr("R5 ram word wr", 16'(a), {8'(a ^ 8'h3C), 8'(a)}, 1'b0);
    for (int a = 16'h0200; a < 16'h0280; a++) rd("R5 ram byte rd", 16'(a), 1'b1);
    for (int a = 16'h0201; a < 16'h0280; a += 4) wr("R6 ram byte wr", 16'(a), 16'hC3EE, 1'b1);
    for (int a = 16'h0200; a < 16'h0280; a += 2) rd("R6 ram word rd", 16'(a), 1'b0);
    wr("R2 odd word wr", 16'h0231, 16'h1111, 1'b0);
    rd("R2 odd word rd", 16'h0231, 1'b0);
    rd("R4 ram unchanged", 16'h0230, 1'b0);
    rd("R4 ram unchanged", 16'h0232, 1'b0);
    rd("R2 odd word unmapped", 16'h0301, 1'b0);

    // image and vectors
    for (int a = 16'hF800; a <= 16'hFFFE; a += 2) rd("R7 image word", 16'(a), 1'b0);
    for (int a = 16'hFFD0; a <= 16'hFFFF; a++) rd("R7 image byte", 16'(a), 1'b1);
    wr("R7 image wr", 16'hF900, 16'h0000, 1'b0);
    wr("R7 vector wr", 16'hFFFE, 16'h0000, 1'b0);
    wr("R7 vector byte wr", 16'hFFE1, 16'h0000, 1'b1);
    rd("R7 image after wr", 16'hF900, 1'b0);
    rd("R7 vector after wr", 16'hFFFE, 1'b0);

    // unmapped bands
    for (int a = 16'h0280; a < 16'h0300; a += 2) begin
      wr("R8 unmapped wr", 16'(a), 16'h5A5A, 1'b0);
      rd("R8 unmapped rd", 16'(a), 1'b0);
      rd("R8 unmapped byte", 16'(a + 1), 1'b1);
    end
    for (int a = 16'hF7F0; a < 16'hF800; a++) rd("R8 below image", 16'(a), 1'b1);
    rd("R8 mid space", 16'h8000, 1'b0);

    // mid-run reset
    do_reset();
    sweep_zero("R10 second reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule